// File: doc/BRIEF.md
# Four-Way Recency Order Tracker

This block keeps, for every set of a four-way set-associative cache, the order in which the four ways were last used, running from most recent to least recent. Each set's order is stored in five bits. The first two fields hold the numbers of the two most recent ways. The last bit says which of the two remaining ways was used more recently.

The cache controller presents a set index with an access strobe. On a hit it also gives the number of the way that matched. The block answers at once, without a register in the path, with the least-recently-used way of the addressed set. That way is the one to refill when the access misses. On each clock edge that carries a valid access, the addressed set's order is updated. A hit moves the hit way to the front. A miss moves the victim to the front. Tag compare, data arrays and memory traffic belong to the surrounding cache.

Top module: `lru_hl_tracker`

## Requirements
- R1: After reset, every set holds the order (0,1,2,3), from most recent to least recent, so the first victim reported for any set is way 3.
- R2: A valid access with `acc_hit_i`=1 moves `acc_hit_way_i` to the most-recent position. The other three ways keep their relative order. Example: (0,1,2,3) with a hit on way 2 becomes (2,0,1,3), and a hit on way 1 then gives (1,2,0,3).
- R3: A hit on the way already at the most-recent position leaves that set's order unchanged.
- R4: A valid access with `acc_hit_i`=0 takes the least-recent way as the victim. That way becomes the most recent and the other ways shift back by one place. Example: (1,2,0,3) becomes (3,1,2,0).
- R5: `victim_way_o` is, in the same cycle and without a register, the least-recent way of the set selected by `acc_set_i`. `fill_valid_o` is 1 exactly when `acc_valid_i`=1 and `acc_hit_i`=0. `fill_way_o` equals `victim_way_o`.
- R6: An access changes only the set it addresses. Every other set's order stays the same.
- R7: While `acc_valid_i`=0, no set's order changes, whatever the values of `acc_hit_i`, `acc_hit_way_i` and `acc_set_i`.
- R8: `order_o` shows the addressed set's order as four 2-bit way numbers. Bits [7:6] hold the most recent way and bits [1:0] the least recent. The four numbers are always a permutation of 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state updates on the rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_set_i | input | SET_W | Set index of the current access |
| acc_valid_i | input | 1 | Access strobe |
| acc_hit_i | input | 1 | 1 when the access hit, 0 when it missed |
| acc_hit_way_i | input | 2 | Way that hit (used only when acc_hit_i=1) |
| victim_way_o | output | 2 | Least-recently-used way of the addressed set |
| fill_valid_o | output | 1 | Current access is a miss that fills fill_way_o |
| fill_way_o | output | 2 | Way being refilled on a miss |
| order_o | output | 8 | Decoded order of the addressed set, most recent in [7:6] |

## Verification
The bench goes after several corner cases.

- A hit on the way already at the front: a design that rebuilt the order blindly would disturb the tail.
- Promotion from each of the four positions: an off-by-one in the shift would drop or duplicate a way.
- The polarity of the tie bit between the two hidden ways: getting it backwards swaps the last two ways and makes every later victim wrong.
- Set isolation and the idle strobe: a design that failed either would corrupt orders it was never asked to touch.

These cases are exercised first with the ordering examples, then by a long random stream of hits and misses across all sets. That stream is compared every cycle against a permutation model in the bench.

// File: rtl/lru_hl_pkg.sv
package lru_hl_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [WAY_W-1:0] way_t;

    // Recency order, element 0 is the most recent way.
    typedef logic [0:WAYS-1][WAY_W-1:0] order_t;

    // Packed per-set state: two leading ways and the hidden-pair selector.
    typedef struct packed {
        way_t first;
        way_t second;
        logic pick_hi;
    } hl_code_t;

    localparam hl_code_t RESET_CODE = '{first: 2'd0, second: 2'd1, pick_hi: 1'b0};

endpackage

// File: rtl/hl_decode.sv
module hl_decode
    import lru_hl_pkg::*;
(
    input  hl_code_t code_i,
    output order_t   order_o
);

    way_t lo_way;
    way_t hi_way;

    // Find the two ways absent from the leading fields, in ascending order.
    always_comb begin
        int found;
        lo_way = '0;
        hi_way = '0;
        found  = 0;
        for (int v = 0; v < WAYS; v++) begin
            if (way_t'(v) != code_i.first && way_t'(v) != code_i.second) begin
                if (found == 0) lo_way = way_t'(v);
                else            hi_way = way_t'(v);
                found++;
            end
        end
    end

    always_comb begin
        order_o[0] = code_i.first;
        order_o[1] = code_i.second;
        order_o[2] = code_i.pick_hi ? hi_way : lo_way;
        order_o[3] = code_i.pick_hi ? lo_way : hi_way;
    end

endmodule

// File: rtl/hl_encode.sv
module hl_encode
    import lru_hl_pkg::*;
(
    input  order_t   order_i,
    output hl_code_t code_o
);

    always_comb begin
        code_o.first   = order_i[0];
        code_o.second  = order_i[1];
        code_o.pick_hi = (order_i[2] > order_i[3]);
    end

endmodule

// File: rtl/order_promote.sv
module order_promote
    import lru_hl_pkg::*;
(
    input  order_t order_i,
    input  way_t   way_i,
    output order_t order_o
);

    localparam int POS_W = $clog2(WAYS);

    logic [POS_W-1:0] pos;

    always_comb begin
        pos = POS_W'(WAYS - 1);
        for (int p = WAYS - 1; p >= 0; p--) begin
            if (order_i[p] == way_i) pos = POS_W'(p);
        end
    end

    // Ways ahead of the promoted one slide back one place; the rest stay.
    always_comb begin
        order_o[0] = way_i;
        for (int k = 1; k < WAYS; k++) begin
            if (k <= int'(pos)) order_o[k] = order_i[k-1];
            else                order_o[k] = order_i[k];
        end
    end

endmodule

// File: rtl/lru_hl_tracker.sv
module lru_hl_tracker
    import lru_hl_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SET_W-1:0] acc_set_i,
    input  logic             acc_valid_i,
    input  logic             acc_hit_i,
    input  logic [1:0]       acc_hit_way_i,
    output logic [1:0]       victim_way_o,
    output logic             fill_valid_o,
    output logic [1:0]       fill_way_o,
    output logic [7:0]       order_o
);

    typedef hl_code_t [NUM_SETS-1:0] code_arr_t;

    typedef struct packed {
        code_arr_t codes;
    } state_t;

    state_t   state_d, state_q;
    hl_code_t cur_code;
    hl_code_t new_code;
    order_t   cur_order;
    order_t   new_order;
    way_t     target_way;

    assign cur_code = state_q.codes[acc_set_i];

    hl_decode u_decode (
        .code_i  (cur_code),
        .order_o (cur_order)
    );

    assign victim_way_o = cur_order[WAYS-1];
    assign fill_way_o   = cur_order[WAYS-1];
    assign fill_valid_o = acc_valid_i && !acc_hit_i;
    assign order_o      = cur_order;
    assign target_way   = acc_hit_i ? acc_hit_way_i : cur_order[WAYS-1];

    order_promote u_promote (
        .order_i (cur_order),
        .way_i   (target_way),
        .order_o (new_order)
    );

    hl_encode u_encode (
        .order_i (new_order),
        .code_o  (new_code)
    );

    always_comb begin
        state_d = state_q;
        if (acc_valid_i) state_d.codes[acc_set_i] = new_code;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int s = 0; s < NUM_SETS; s++) state_q.codes[s] <= RESET_CODE;
        end else begin
            state_q <= state_d;
        end
    end

    // R2: the way that hit becomes the most recent in the stored state.
    a_r2_hit_to_front: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && acc_hit_i) |=>
            state_q.codes[$past(acc_set_i)].first == $past(acc_hit_way_i));

    // R4: the reported victim becomes the most recent way after a miss.
    a_r4_miss_victim_front: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && !acc_hit_i) |=>
            state_q.codes[$past(acc_set_i)].first == $past(victim_way_o));

    // R3: a hit on the front way leaves the set's code untouched.
    a_r3_front_hit_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && acc_hit_i && acc_hit_way_i == order_o[7:6]) |=>
            state_q.codes[$past(acc_set_i)] == $past(state_q.codes[acc_set_i]));

    // R7: without a strobe the whole state array holds.
    a_r7_idle_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc_valid_i |=> state_q == $past(state_q));

    // R8: the two leading fields never name the same way.
    a_r8_distinct_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_code.first != cur_code.second);

    // R5: the victim is never one of the two most recent ways.
    a_r5_victim_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
        victim_way_o != cur_code.first && victim_way_o != cur_code.second);

endmodule

// File: tb/lru_hl_tracker_tb.sv
`timescale 1ns/100ps
module lru_hl_tracker_tb_top;

    localparam int NSETS = 16;
    localparam int SW    = $clog2(NSETS);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [SW-1:0] set_r;
    logic          valid_r;
    logic          hit_r;
    logic [1:0]    way_r;
    logic [1:0]    victim;
    logic          fill_v;
    logic [1:0]    fill_w;
    logic [7:0]    order;

    int ref_ord [NSETS][4];
    int tests  = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    lru_hl_tracker #(.NUM_SETS(NSETS)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .acc_set_i     (set_r),
        .acc_valid_i   (valid_r),
        .acc_hit_i     (hit_r),
        .acc_hit_way_i (way_r),
        .victim_way_o  (victim),
        .fill_valid_o  (fill_v),
        .fill_way_o    (fill_w),
        .order_o       (order)
    );

    task automatic chk(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic int exp_order(input int s);
        return (ref_ord[s][0] << 6) | (ref_ord[s][1] << 4) | (ref_ord[s][2] << 2) | ref_ord[s][3];
    endfunction

    function automatic void ref_promote(input int s, input int w);
        int p = 3;
        for (int k = 0; k < 4; k++) if (ref_ord[s][k] == w) p = k;
        for (int k = p; k > 0; k--) ref_ord[s][k] = ref_ord[s][k-1];
        ref_ord[s][0] = w;
    endfunction

    task automatic check_set_outputs(input string req, input int s);
        chk(req, int'(order), exp_order(s));
        chk(req, int'(victim), ref_ord[s][3]);
    endtask

    // Drive one cycle, check combinational outputs, then update the model.
    task automatic step(input int s, input bit v, input bit h, input int w, input string req);
        @(negedge clk);
        set_r   = SW'(s);
        valid_r = v;
        hit_r   = h;
        way_r   = 2'(w);
        #1;
        check_set_outputs(req, s);
        chk("R5 fill_valid", int'(fill_v), int'(v && !h));
        chk("R5 fill_way", int'(fill_w), ref_ord[s][3]);
        @(posedge clk);
        if (v) ref_promote(s, h ? w : ref_ord[s][3]);
    endtask

    task automatic peek(input int s, input string req);
        @(negedge clk);
        set_r = SW'(s); valid_r = 0; hit_r = 0; way_r = 0;
        #1;
        check_set_outputs(req, s);
    endtask

    initial begin
        for (int s = 0; s < NSETS; s++) for (int k = 0; k < 4; k++) ref_ord[s][k] = k;
        rst_n = 0; set_r = 0; valid_r = 0; hit_r = 0; way_r = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset order on every set
        for (int s = 0; s < NSETS; s++) peek(s, "R1 reset order");

        // R2 examples
        step(5, 1, 1, 2, "R2 pre-hit2");
        peek(5, "R2 after hit2 -> 2,0,1,3");
        chk("R2 literal", int'(order), 8'b10_00_01_11);
        step(5, 1, 1, 1, "R2 pre-hit1");
        chk("R2 literal", exp_order(5), 8'b01_10_00_11);
        peek(5, "R2 after hit1 -> 1,2,0,3");
        // R4 example
        step(5, 1, 0, 0, "R4 miss victim");
        peek(5, "R4 after miss -> 3,1,2,0");
        chk("R4 literal", int'(order), 8'b11_01_10_00);
        // R3 front hit
        step(5, 1, 1, 3, "R3 front hit");
        peek(5, "R3 unchanged");
        chk("R3 literal", int'(order), 8'b11_01_10_00);
        // R7 idle with noisy inputs
        step(5, 0, 1, 0, "R7 idle hit");
        step(5, 0, 0, 2, "R7 idle miss");
        peek(5, "R7 unchanged");
        // R6 neighbours untouched
        peek(4, "R6 neighbour set 4");
        peek(6, "R6 neighbour set 6");
        // Promotion from each position on set 9
        for (int p = 3; p >= 0; p--) step(9, 1, 1, ref_ord[9][p], "R2 promote by position");
        peek(9, "R2 after position sweep");

        // Random stream against the permutation model (R2 R4 R5 R6 R8)
        for (int i = 0; i < 3000; i++) begin
            int s = $urandom_range(NSETS-1);
            bit v = ($urandom_range(7) != 0);
            bit h = $urandom_range(1);
            int w = $urandom_range(3);
            step(s, v, h, w, "R8 random order");
        end
        for (int s = 0; s < NSETS; s++) peek(s, "R6 final sweep");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule